// File: doc/BRIEF.md
# Boot-Overlay Memory Address Decoder

This block sits on the bus of a 68010-class processor. For every request it names one target: a boot ROM, main RAM, a small frame-buffer RAM, a single control register, or nothing. A request carries a 24-bit byte address, a transfer size (byte, word or long), a direction and write data. The block splits write data into bytes and gathers read bytes in big-endian order: the byte at the lowest address sits in the most significant lane of the transfer.

Out of reset a boot overlay is active. While it is active, address bit 23 is forced high before decoding, so code fetched at address zero comes from the ROM. A write to the control register restores the normal map. An access that reaches no target raises a one-cycle miss strobe and reports the effective address. A read of that kind returns all ones for its size. The RAM and the frame buffer are modelled as synchronous byte arrays. The ROM contents are a fixed computed pattern. A read answers one clock after its request.

Top module: `bootmap_decoder`

## Requirements
- R1: After reset the normal-map flag is clear. While it is clear, the decoder uses the address with bit 23 set. An address with bit 22 clear then reads ROM and raises no miss. An address with bit 22 set lands at 0xC00000 or above and is a miss.
- R2: A write to 0xE43000 is not a miss. A word or long write (size code 1 or 2) loads the flag from wdata bit 15 and ignores bit 7. A byte write (size code 0) loads the flag from wdata bit 7 and ignores bit 15. A read of 0xE43000 is a miss.
- R3: The effective range 0x800000 to 0xBFFFFF is ROM. The ROM byte at effective address e is p(o) = o[7:0] ^ o[15:8] ^ o[23:16] ^ 0xC3, where o = e & (ROM_BYTES-1) and ROM_BYTES defaults to 16384. The ROM therefore repeats every ROM_BYTES bytes, and the bytes of one transfer wrap inside it.
- R4: A write that decodes to ROM changes no state and raises no strobe.
- R5: An effective address below RAM_LIMIT (default 0x080000) is main RAM. The RAM holds RAM_STORE bytes (default 2048), indexed by the low address bits.
- R6: The range 0x420000 to 0x427FFF is the frame buffer. It holds VRAM_STORE bytes (default 2048), indexed by the low address bits. 0x428000 is outside it.
- R7: The size code is 0 for byte, 1 for word and 2 (or 3) for long. Data is big-endian. A long uses wdata/rdata [31:24] for the lowest address. A word uses [15:8] for the lower byte and [7:0] for the upper byte. A byte uses [7:0]. The unused upper read bits are zero.
- R8: A read that reaches no target returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF by size. It sets rvalid and io_miss together, and miss_addr holds the effective address.
- R9: A write that reaches no target and is not a control write raises io_miss for one cycle with the effective address. It raises no rvalid and changes no state.
- R10: A read request raises rvalid exactly in the following cycle. A cycle without a request raises neither rvalid nor io_miss, and rdata is zero whenever rvalid is low.
- R11: While rst_n is low, rvalid and io_miss are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Transfer size code |
| addr | input | 24 | Byte address from the processor |
| wdata | input | 32 | Write data, right-justified by size |
| rvalid | output | 1 | Read data valid (one cycle after a read) |
| rdata | output | 32 | Read data, right-justified by size |
| io_miss | output | 1 | The previous cycle's access reached no target |
| miss_addr | output | 24 | Effective address of the missed access |

## Verification
On every cycle, properties check four things. The response timing holds and idle cycles stay quiet. While the overlay is active, low addresses never miss and ROM writes stay silent. The control write loads the flag from the correct data bit. Every missed read comes back all ones for its size. Only the bench scenarios can show that the data itself is right. Those scenarios cover big-endian packing across all sizes, ROM mirroring and wrap, storage contents surviving a discarded ROM write or a stray unmapped write, and the edges of the RAM and frame-buffer ranges.

// File: rtl/bootmap_pkg.sv
// Shared types and helpers for the boot-overlay decoder.
// Assumes a 24-bit byte address and a 32-bit data path.
package bootmap_pkg;
    localparam int unsigned AW = 24;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_sz_e;

    typedef enum logic [2:0] {
        TGT_ROM  = 3'd0,
        TGT_RAM  = 3'd1,
        TGT_VRAM = 3'd2,
        TGT_CTRL = 3'd3,
        TGT_NONE = 3'd4
    } tgt_e;

    // Number of bytes moved by a size code (reserved code moves four).
    function automatic logic [2:0] sz_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Fixed boot ROM contents, computed from the offset inside the ROM.
    function automatic logic [7:0] rom_pattern(input logic [AW-1:0] off);
        return off[7:0] ^ off[15:8] ^ off[23:16] ^ 8'hC3;
    endfunction
endpackage

// File: rtl/bootmap_decode.sv
// Address decoder: applies the boot overlay, then names one target.
// Priority is ROM window, RAM, frame buffer, control register (writes only).
// Purely combinational; assumes the region parameters do not wrap past 2^AW.
module bootmap_decode
    import bootmap_pkg::*;
#(
    parameter int unsigned     OVL_BIT   = 23,
    parameter logic [AW-1:0]   ROM_BASE  = 24'h800000,
    parameter logic [AW-1:0]   ROM_LAST  = 24'hBFFFFF,
    parameter logic [AW-1:0]   RAM_LIMIT = 24'h080000,
    parameter logic [AW-1:0]   VRAM_BASE = 24'h420000,
    parameter logic [AW-1:0]   VRAM_LAST = 24'h427FFF,
    parameter logic [AW-1:0]   CTRL_ADDR = 24'hE43000
) (
    input  logic          map_normal,
    input  logic          we,
    input  logic [AW-1:0] cpu_addr,
    output logic [AW-1:0] eff_addr,
    output tgt_e          target
);
    localparam logic [AW-1:0] OVL_MASK = AW'(1) << OVL_BIT;

    // Force the overlay bit while the normal map is off.
    always_comb eff_addr = map_normal ? cpu_addr : (cpu_addr | OVL_MASK);

    // Fixed-priority region match on the effective address.
    always_comb begin
        if (eff_addr >= ROM_BASE && eff_addr <= ROM_LAST)
            target = TGT_ROM;
        else if (eff_addr < RAM_LIMIT)
            target = TGT_RAM;
        else if (eff_addr >= VRAM_BASE && eff_addr <= VRAM_LAST)
            target = TGT_VRAM;
        else if (eff_addr == CTRL_ADDR && we)
            target = TGT_CTRL;
        else
            target = TGT_NONE;
    end
endmodule

// File: rtl/bootmap_bytestore.sv
// Synchronous byte array accessed up to four consecutive bytes at a time.
// Byte k of a transfer sits at index base+k, wrapping inside the array.
// Packed form: byte 0 in [31:24]. Assumes DEPTH is a power of two.
module bootmap_bytestore #(
    parameter int unsigned DEPTH = 2048
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] base,
    input  logic [2:0]               nbytes,
    input  logic [31:0]              wbytes,
    output logic [31:0]              rbytes
);
    localparam int unsigned IW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    // Store the leading nbytes of the packed write word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (3'(k) < nbytes)
                    mem[base + IW'(k)] <= wbytes[31-8*k -: 8];
            end
        end
    end

    // Fetch four consecutive bytes; the caller keeps only what it needs.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            for (int k = 0; k < 4; k++)
                rbytes[31-8*k -: 8] <= mem[base + IW'(k)];
        end
    end
endmodule

// File: rtl/bootmap_lanes.sv
// Byte-lane packing between the right-justified bus data and the packed
// lowest-address-first byte word used by the targets. Combinational.
module bootmap_lanes (
    input  logic [1:0]  wr_sz,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] wr_bytes,
    input  logic [1:0]  rd_sz,
    input  logic [31:0] rd_bytes,
    output logic [31:0] cpu_rdata
);
    // Move the valid write bytes to the top of the packed word.
    always_comb begin
        case (wr_sz)
            2'd0:    wr_bytes = {cpu_wdata[7:0], 24'h0};
            2'd1:    wr_bytes = {cpu_wdata[15:0], 16'h0};
            default: wr_bytes = cpu_wdata;
        endcase
    end

    // Right-justify the leading read bytes and zero the rest.
    always_comb begin
        case (rd_sz)
            2'd0:    cpu_rdata = {24'h0, rd_bytes[31:24]};
            2'd1:    cpu_rdata = {16'h0, rd_bytes[31:16]};
            default: cpu_rdata = rd_bytes;
        endcase
    end
endmodule

// File: rtl/bootmap_decoder.sv
// Boot-overlay memory decoder top. It decodes each bus request, writes the
// RAM and frame buffer, and drops ROM writes. It holds the normal-map flag
// and answers reads one cycle later. Misses are flagged with their
// effective address. Assumes at most one request per cycle and
// power-of-two storage and ROM sizes.
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter logic [AW-1:0] RAM_LIMIT  = 24'h080000,
    parameter int unsigned   RAM_STORE  = 2048,
    parameter int unsigned   VRAM_STORE = 2048,
    parameter int unsigned   ROM_BYTES  = 16384,
    parameter logic [AW-1:0] VRAM_BASE  = 24'h420000,
    parameter logic [AW-1:0] VRAM_LAST  = 24'h427FFF,
    parameter logic [AW-1:0] CTRL_ADDR  = 24'hE43000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic          rvalid,
    output logic [31:0]   rdata,
    output logic          io_miss,
    output logic [AW-1:0] miss_addr
);
    localparam int unsigned   RAM_IW   = $clog2(RAM_STORE);
    localparam int unsigned   VRAM_IW  = $clog2(VRAM_STORE);
    localparam logic [AW-1:0] ROM_MASK = AW'(ROM_BYTES - 1);

    logic          map_normal_q;
    logic [AW-1:0] eff_addr;
    tgt_e          tgt;
    logic [2:0]    nbytes;
    logic [31:0]   wr_bytes;
    logic [31:0]   rom_raw;
    logic [31:0]   rom_raw_q;
    logic [31:0]   ram_raw;
    logic [31:0]   vram_raw;
    logic [31:0]   rd_raw;
    logic [31:0]   rd_word;
    tgt_e          tgt_q;
    logic [1:0]    sz_q;
    logic          rvalid_q;
    logic          miss_q;
    logic [AW-1:0] miss_addr_q;

    bootmap_decode #(
        .RAM_LIMIT (RAM_LIMIT),
        .VRAM_BASE (VRAM_BASE),
        .VRAM_LAST (VRAM_LAST),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_decode (
        .map_normal (map_normal_q),
        .we         (we),
        .cpu_addr   (addr),
        .eff_addr   (eff_addr),
        .target     (tgt)
    );

    // Transfer length in bytes for the current request.
    always_comb nbytes = sz_bytes(size);

    bootmap_lanes u_lanes (
        .wr_sz     (size),
        .cpu_wdata (wdata),
        .wr_bytes  (wr_bytes),
        .rd_sz     (sz_q),
        .rd_bytes  (rd_raw),
        .cpu_rdata (rd_word)
    );

    bootmap_bytestore #(.DEPTH(RAM_STORE)) u_ram (
        .clk    (clk),
        .wr_en  (req && we && tgt == TGT_RAM),
        .rd_en  (req && !we && tgt == TGT_RAM),
        .base   (eff_addr[RAM_IW-1:0]),
        .nbytes (nbytes),
        .wbytes (wr_bytes),
        .rbytes (ram_raw)
    );

    bootmap_bytestore #(.DEPTH(VRAM_STORE)) u_vram (
        .clk    (clk),
        .wr_en  (req && we && tgt == TGT_VRAM),
        .rd_en  (req && !we && tgt == TGT_VRAM),
        .base   (eff_addr[VRAM_IW-1:0]),
        .nbytes (nbytes),
        .wbytes (wr_bytes),
        .rbytes (vram_raw)
    );

    // One ROM lane per byte of a transfer, each wrapped inside the ROM size.
    for (genvar k = 0; k < 4; k++) begin : g_rom_lane
        assign rom_raw[31-8*k -: 8] = rom_pattern((eff_addr + AW'(k)) & ROM_MASK);
    end

    // Normal-map flag: cleared by reset, loaded by a control-register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_normal_q <= 1'b0;
        else if (req && we && tgt == TGT_CTRL)
            map_normal_q <= (size == SZ_BYTE) ? wdata[7] : wdata[15];
    end

    // Response stage: strobes plus what the read mux needs next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q    <= 1'b0;
            miss_q      <= 1'b0;
            miss_addr_q <= '0;
            tgt_q       <= TGT_NONE;
            sz_q        <= SZ_BYTE;
            rom_raw_q   <= '0;
        end else begin
            rvalid_q <= req && !we;
            miss_q   <= req && tgt == TGT_NONE;
            if (req) begin
                tgt_q       <= tgt;
                sz_q        <= size;
                rom_raw_q   <= rom_raw;
                miss_addr_q <= eff_addr;
            end
        end
    end

    // Pick the packed bytes of the answering target; a miss reads all ones.
    always_comb begin
        case (tgt_q)
            TGT_ROM:  rd_raw = rom_raw_q;
            TGT_RAM:  rd_raw = ram_raw;
            TGT_VRAM: rd_raw = vram_raw;
            default:  rd_raw = 32'hFFFF_FFFF;
        endcase
    end

    assign rvalid    = rvalid_q;
    assign rdata     = rvalid_q ? rd_word : 32'h0;
    assign io_miss   = miss_q;
    assign miss_addr = miss_addr_q;

    // R11: strobes are low through reset.
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!rvalid && !io_miss));

    // R10: every read is answered in the next cycle.
    p_read_answered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);

    // R10: no request, no strobe.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!rvalid && !io_miss));

    // R9: writes never produce read data.
    p_write_no_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |=> !rvalid);

    // R1: under the overlay, a low address with bit 22 clear never misses.
    p_overlay_rom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !map_normal_q && !addr[22]) |=> !io_miss);

    // R2: word and long control writes load the flag from bit 15.
    p_ctrl_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == CTRL_ADDR && size != SZ_BYTE)
            |=> (map_normal_q == $past(wdata[15])));

    // R8: a missed read returns all ones for its size.
    p_miss_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && io_miss) |-> (rdata == (($past(size) == SZ_BYTE) ? 32'h0000_00FF :
                                           ($past(size) == SZ_WORD) ? 32'h0000_FFFF :
                                                                      32'hFFFF_FFFF)));
endmodule

// File: tb/bootmap_decoder_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each expected response from the
// requirements and queues it, and the monitor compares what arrives.
module bootmap_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [23:0] addr = 24'h0;
    logic [31:0] wdata = 32'h0;
    logic        rvalid;
    logic [31:0] rdata;
    logic        io_miss;
    logic [23:0] miss_addr;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic        rd;
        logic        miss;
        logic [31:0] data;
        logic [23:0] maddr;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic       ovl_normal = 1'b0;
    logic [7:0] ram_m  [2048];
    logic [7:0] vram_m [2048];

    always #2 clk = ~clk;

    bootmap_decoder dut_i (
        .clk (clk), .rst_n (rst_n), .req (req), .we (we), .size (size),
        .addr (addr), .wdata (wdata), .rvalid (rvalid), .rdata (rdata),
        .io_miss (io_miss), .miss_addr (miss_addr)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Region codes: 0 ROM, 1 RAM, 2 frame buffer, 3 control, 4 none.
    function automatic int region(input logic [23:0] e, input logic w);
        if (e >= 24'h800000 && e <= 24'hBFFFFF) return 0;
        if (e < 24'h080000) return 1;
        if (e >= 24'h420000 && e <= 24'h427FFF) return 2;
        if (e == 24'hE43000 && w) return 3;
        return 4;
    endfunction

    function automatic logic [7:0] byte_at(input int rg, input logic [23:0] a);
        logic [23:0] o;
        o = a & 24'h003FFF;
        case (rg)
            0:       return o[7:0] ^ o[15:8] ^ o[23:16] ^ 8'hC3;
            1:       return ram_m[a[10:0]];
            default: return vram_m[a[10:0]];
        endcase
    endfunction

    function automatic int nb(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic acc(input logic w, input logic [1:0] sz, input logic [23:0] a,
                       input logic [31:0] d, input string tag);
        logic [23:0] e;
        logic [31:0] v;
        int rg;
        e  = ovl_normal ? a : (a | 24'h800000);
        rg = region(e, w);
        if (!w) begin
            v = 0;
            for (int k = 0; k < nb(sz); k++)
                v = (v << 8) | ((rg == 4) ? 32'hFF : 32'(byte_at(rg, e + 24'(k))));
            exp_q.push_back('{1'b1, rg == 4, v, e, tag});
        end else if (rg == 4) begin
            exp_q.push_back('{1'b0, 1'b1, 32'h0, e, tag});
        end else if (rg == 1 || rg == 2) begin
            for (int k = 0; k < nb(sz); k++) begin
                v = d >> (8 * (nb(sz) - 1 - k));
                if (rg == 1) ram_m[11'(e + 24'(k))] = v[7:0];
                else         vram_m[11'(e + 24'(k))] = v[7:0];
            end
        end else if (rg == 3) begin
            ovl_normal = (sz == 2'd0) ? d[7] : d[15];
        end
        @(negedge clk);
        req = 1'b1; we = w; size = sz; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    // Monitor: reset quiet check, then pop and compare each response.
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R11 rvalid in reset", 32'(rvalid), 32'h0);
            chk("R11 io_miss in reset", 32'(io_miss), 32'h0);
        end else if (rvalid || io_miss) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected strobe", {30'h0, rvalid, io_miss}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " rvalid"}, 32'(rvalid), 32'(e.rd));
                chk({e.tag, " io_miss"}, 32'(io_miss), 32'(e.miss));
                if (e.rd)   chk({e.tag, " rdata"}, rdata, e.data);
                if (e.miss) chk({e.tag, " miss_addr"}, 32'(miss_addr), 32'(e.maddr));
            end
        end else if (rdata !== 32'h0) begin
            chk("R10 rdata idle", rdata, 32'h0);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1/R3: overlay active, low addresses read ROM
        acc(0, 2'd2, 24'h000000, 0, "R1 overlay long 0");
        acc(0, 2'd1, 24'h001236, 0, "R1 overlay word");
        acc(0, 2'd0, 24'h3FFFFF, 0, "R3 overlay top byte");
        acc(0, 2'd2, 24'h400000, 0, "R1 overlay bit22 miss");
        // R4: ROM write under overlay is silent; R2 word write sets the flag
        acc(1, 2'd2, 24'h000100, 32'hDEADBEEF, "R4 rom write");
        acc(1, 2'd1, 24'hE43000, 32'h0000_8000, "R2 ctrl word set");
        // R5/R7: RAM packing
        acc(1, 2'd2, 24'h000100, 32'h11223344, "R5 ram long wr");
        for (int k = 0; k < 4; k++)
            acc(0, 2'd0, 24'h000100 + 24'(k), 0, "R7 ram byte lanes");
        acc(0, 2'd1, 24'h000102, 0, "R7 ram word");
        acc(0, 2'd2, 24'h000100, 0, "R7 ram long");
        acc(1, 2'd0, 24'h000104, 32'hFFFF_FF5A, "R7 byte wr");
        acc(1, 2'd0, 24'h000105, 32'h0000_00AB, "R7 byte wr");
        acc(1, 2'd1, 24'h000106, 32'h1234_CDEF, "R7 word wr");
        acc(0, 2'd2, 24'h000104, 0, "R7 mixed long rd");
        // R2: byte write takes bit 7 (bit 15 ignored)
        acc(1, 2'd0, 24'hE43000, 32'h0000_8000, "R2 ctrl byte clear");
        acc(1, 2'd2, 24'h000100, 32'hCAFEBABE, "R4 rom write overlay");
        acc(0, 2'd2, 24'h000100, 0, "R1 overlay reads rom");
        acc(1, 2'd0, 24'hE43000, 32'h0000_0080, "R2 ctrl byte set");
        acc(0, 2'd2, 24'h000100, 0, "R4 ram kept after rom write");
        // R2: word write takes bit 15 (bit 7 ignored), then long sets again
        acc(1, 2'd1, 24'hE43000, 32'h0000_0080, "R2 ctrl word clear");
        acc(0, 2'd1, 24'h000100, 0, "R2 overlay back");
        acc(1, 2'd2, 24'hE43000, 32'h0000_8000, "R2 ctrl long set");
        // R3: ROM window mirror and wrap
        acc(0, 2'd2, 24'h800000, 0, "R3 rom base");
        acc(0, 2'd2, 24'h804000, 0, "R3 rom mirror");
        acc(0, 2'd2, 24'hBFFFFE, 0, "R3 rom wrap");
        // R6: frame buffer and its edges
        acc(1, 2'd2, 24'h420004, 32'hCAFEF00D, "R6 vram long wr");
        acc(0, 2'd1, 24'h420006, 0, "R6 vram word");
        acc(0, 2'd0, 24'h420004, 0, "R6 vram byte");
        acc(1, 2'd0, 24'h427FFF, 32'h0000_0077, "R6 vram last wr");
        acc(0, 2'd0, 24'h427FFF, 0, "R6 vram last");
        acc(0, 2'd0, 24'h428000, 0, "R6 past vram miss");
        // R5: RAM limit edge
        acc(1, 2'd0, 24'h07FFFF, 32'h0000_0099, "R5 ram last wr");
        acc(0, 2'd0, 24'h07FFFF, 0, "R5 ram last");
        acc(0, 2'd0, 24'h080000, 0, "R5 past ram miss");
        // R8: unmapped reads by size, control read
        acc(0, 2'd2, 24'h600000, 0, "R8 miss long");
        acc(0, 2'd1, 24'h600002, 0, "R8 miss word");
        acc(0, 2'd2, 24'hE43000, 0, "R8 ctrl read miss");
        // R9: unmapped write changes nothing
        acc(1, 2'd2, 24'h600010, 32'h0000_0000, "R9 miss write");
        acc(0, 2'd2, 24'h000100, 0, "R9 state kept");
        repeat (3) @(negedge clk);
        chk("R10 queue drained", 32'(exp_q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule